// File: doc/BRIEF.md
# Pipelined CORDIC Coefficient Plane Rotator

This block turns the four type-II 2-D cosine/sine transform coefficients of one frequency index pair into their type-I counterparts. The four coefficients are the cosine-cosine, cosine-sine, sine-cosine and sine-sine kinds. They belong to the previous frame, and the block works on them while the transform upstream is producing the next frame's coefficients. The work is done with plane rotations built from shift-and-add CORDIC micro-rotations, so the block contains no hardware multiplier. The coefficients are grouped into two pairs, (cosine-cosine, cosine-sine) and (sine-cosine, sine-sine). Both pairs are turned through the same angle in the same pass.

The caller does not give the angle as a number. It gives a vector of micro-rotation directions that was computed ahead of time for the frequency index. A mode bit picks the circular forward or the circular backward sense. An accepted set of inputs is first captured in a one-cycle register bank. It then passes through one registered stage per micro-rotation. A final stage applies a fixed shift-add gain correction and saturates each result to 12 bits. A result leaves the block together with a valid strobe.

Top module: `cordic_pair_rotator`

## Requirements
- R1: While `rst_n` is low at a rising edge, the output registers clear: `out_valid` reads 0 and all four output coefficients read 0. In the first ITER edges after reset is released, `out_valid` stays 0.
- R2: An input set is accepted at a rising edge where `in_valid` is 1. Its result appears with `out_valid` = 1 exactly ITER+1 edges later. Results come out one per accepted set, in the order accepted, and sets may arrive on back-to-back cycles.
- R3: In forward mode (`in_mode` = 0) with ITER = 8, pair A works as follows. Set x = `in_cc`·4 and y = `in_cs`·4, which gives 2 fraction bits. For i = 0..7: let xs = x>>>i and ys = y>>>i, both arithmetic shifts. If `in_dirs[i]` = 1, then x ← x − ys and y ← y + xs; otherwise x ← x + ys and y ← y − xs. Each result is then g(v) = ((v>>>1)+(v>>>3)−(v>>>6)−(v>>>9))>>>2, and `out_cc` = g(x), `out_cs` = g(y), both subject to R6.
- R4: In backward mode (`in_mode` = 1), every direction bit is inverted before use. The result equals the forward result for `~in_dirs`.
- R5: Pair B (`in_sc`→x, `in_ss`→y, giving `out_sc`, `out_ss`) goes through the same R3/R4 arithmetic with the same directions. Its result does not depend on pair A, and pair A's result does not depend on pair B.
- R6: A corrected value above 2047 comes out as 2047, and one below −2048 comes out as −2048. Saturation never turns a positive result into a negative one or the reverse.
- R7: For a pair whose larger input magnitude is at least 500 and whose inputs each lie within ±1400, the squared magnitude of the output is within 4% of the squared magnitude of the input.
- R8: Coefficients, mode and directions presented while `in_valid` is 0 have no effect on any output. They produce no result and leave later results unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input set strobe |
| in_mode | input | 1 | 0 = circular forward, 1 = circular backward |
| in_dirs | input | ITER | Micro-rotation directions, bit i drives micro-rotation i (1 = counter-clockwise) |
| in_cc | input | COEF_W | Cosine-cosine coefficient, two's complement |
| in_cs | input | COEF_W | Cosine-sine coefficient, two's complement |
| in_sc | input | COEF_W | Sine-cosine coefficient, two's complement |
| in_ss | input | COEF_W | Sine-sine coefficient, two's complement |
| out_valid | output | 1 | Result strobe |
| out_cc | output | COEF_W | Rotated cosine-cosine coefficient |
| out_cs | output | COEF_W | Rotated cosine-sine coefficient |
| out_sc | output | COEF_W | Rotated sine-cosine coefficient |
| out_ss | output | COEF_W | Rotated sine-sine coefficient |

## Verification
The assertions rely on three assumptions.

First, reset is held for at least one edge before any strobe arrives. This lets the in-flight count and the quiet window after reset both start from empty. The bench always starts this way.

Second, the register bank only has to hold its contents across cycles where the strobe is low. To test this, the bench drives random coefficients, modes and directions during every idle gap, so a bank that captured without the strobe would corrupt later results.

Third, the check that saturation preserves sign assumes the guard bits absorb all CORDIC growth for any 12-bit input. The stimulus pushes the extreme codes 2047 and −2048 through an angle of about 45° to reach exactly that bound.

// File: rtl/cpr_pkg.sv
// Package: shared constants for the coefficient plane rotator.
// Holds the default widths, the guard-bit budget and the shift amounts of
// the fixed gain correction, which is tuned for about eight micro-rotations.
package cpr_pkg;

    localparam int CPR_COEF_W = 12;   // coefficient word width
    localparam int CPR_ITER   = 8;    // micro-rotation count
    localparam int CPR_FRAC   = 2;    // fraction bits kept inside the pipe
    localparam int CPR_GUARD  = 2;    // integer guard bits for CORDIC growth
    localparam int CPR_LANES  = 4;    // cc, cs, sc, ss

    // Shifts of the gain correction 1/K ~ 2^-1 + 2^-3 - 2^-6 - 2^-9
    localparam int GAIN_SH_A = 1;
    localparam int GAIN_SH_B = 3;
    localparam int GAIN_SH_C = 6;
    localparam int GAIN_SH_D = 9;

    typedef enum logic {
        ROT_FWD = 1'b0,
        ROT_BWD = 1'b1
    } rot_mode_e;

endpackage

// File: rtl/cpr_bank.sv
// Module: one-cycle input register bank.
// Captures the four previous-frame coefficients and the direction vector
// when the strobe is high and holds them otherwise. Backward mode is folded
// in here by inverting the direction vector once.
// Assumes: synchronous active-low reset; inputs are stable at the edge.
module cpr_bank
    import cpr_pkg::*;
#(
    parameter int W     = CPR_COEF_W,
    parameter int ITER  = CPR_ITER,
    parameter int LANES = CPR_LANES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        vld_in,
    input  logic                        mode_in,
    input  logic [ITER-1:0]             dir_in,
    input  logic [LANES-1:0][W-1:0]     data_in,
    output logic                        vld_q,
    output logic [ITER-1:0]             dir_q,
    output logic [LANES-1:0][W-1:0]     data_q
);

    // Purpose: capture a new coefficient set on the strobe, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            dir_q  <= '0;
            data_q <= '0;
        end else begin
            vld_q <= vld_in;
            if (vld_in) begin
                dir_q  <= (rot_mode_e'(mode_in) == ROT_BWD) ? ~dir_in : dir_in;
                data_q <= data_in;
            end
        end
    end

    // Data seen without the strobe must not reach the bank (R8)
    assert_bank_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_in |=> ($stable(data_q) && $stable(dir_q)));

endmodule

// File: rtl/cpr_micro_rot.sv
// Module: one combinational CORDIC micro-rotation applied to every lane pair.
// Even lanes are x, odd lanes are y. The shift amount is fixed per
// instance, so the stage reduces to two arithmetic shifts and two adders
// for each pair.
// Assumes: the word is wide enough that x and y never wrap.
module cpr_micro_rot
    import cpr_pkg::*;
#(
    parameter int IW    = CPR_COEF_W + CPR_GUARD + CPR_FRAC,
    parameter int SHIFT = 0,
    parameter int LANES = CPR_LANES
) (
    input  logic [LANES-1:0][IW-1:0] lanes_in,
    input  logic                     rot_ccw,
    output logic [LANES-1:0][IW-1:0] lanes_out
);

    localparam int PAIRS = LANES / 2;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        logic signed [IW-1:0] x_cur, y_cur, x_sh, y_sh;

        // Purpose: shift-and-add micro-rotation of one (x, y) pair.
        always_comb begin
            x_cur = $signed(lanes_in[2*p]);
            y_cur = $signed(lanes_in[2*p+1]);
            x_sh  = x_cur >>> SHIFT;
            y_sh  = y_cur >>> SHIFT;
            if (rot_ccw) begin
                lanes_out[2*p]   = x_cur - y_sh;
                lanes_out[2*p+1] = y_cur + x_sh;
            end else begin
                lanes_out[2*p]   = x_cur + y_sh;
                lanes_out[2*p+1] = y_cur - x_sh;
            end
        end
    end

endmodule

// File: rtl/cpr_gain_sat.sv
// Module: fixed CORDIC gain correction, fraction removal and saturation.
// Multiplies by about 0.6074 using four shifted terms, drops the fraction
// bits and clamps the result to the W-bit two's complement range.
// Assumes: the input carries FRAC fraction bits and has not wrapped.
module cpr_gain_sat
    import cpr_pkg::*;
#(
    parameter int W    = CPR_COEF_W,
    parameter int FRAC = CPR_FRAC,
    parameter int IW   = CPR_COEF_W + CPR_GUARD + CPR_FRAC
) (
    input  logic [IW-1:0] val_in,
    output logic [W-1:0]  val_out
);

    localparam logic signed [IW-1:0] SAT_HI = IW'((2 ** (W - 1)) - 1);
    localparam logic signed [IW-1:0] SAT_LO = ~SAT_HI;

    logic signed [IW-1:0] v_s, corr, scaled;

    // Purpose: apply the shift-add gain correction and drop the fraction.
    always_comb begin
        v_s    = $signed(val_in);
        corr   = (v_s >>> GAIN_SH_A) + (v_s >>> GAIN_SH_B)
               - (v_s >>> GAIN_SH_C) - (v_s >>> GAIN_SH_D);
        scaled = corr >>> FRAC;
    end

    // Purpose: clamp the corrected value into the output word range.
    always_comb begin
        if (scaled > SAT_HI) begin
            val_out = SAT_HI[W-1:0];
        end else if (scaled < SAT_LO) begin
            val_out = SAT_LO[W-1:0];
        end else begin
            val_out = scaled[W-1:0];
        end
    end

    // Saturation keeps the sign of the corrected value (R6)
    always_comb begin
        if (scaled > 0) begin
            assert_sat_keeps_sign_R6: assert (!val_out[W-1]);
        end else if (scaled < 0) begin
            assert_sat_neg_sign_R6: assert (val_out[W-1]);
        end
    end

endmodule

// File: rtl/cordic_pair_rotator.sv
// Module: top of the pipelined CORDIC coefficient plane rotator.
// Register bank -> ITER micro-rotation stages with a register between
// each pair of stages -> gain correction and saturation into the output
// register. Latency is ITER+1 edges; the valid strobe runs with the data.
// Assumes: ITER >= 2; the direction vector is precomputed per frequency.
module cordic_pair_rotator
    import cpr_pkg::*;
#(
    parameter int COEF_W = CPR_COEF_W,
    parameter int ITER   = CPR_ITER,
    parameter int FRAC   = CPR_FRAC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_mode,
    input  logic [ITER-1:0]   in_dirs,
    input  logic [COEF_W-1:0] in_cc,
    input  logic [COEF_W-1:0] in_cs,
    input  logic [COEF_W-1:0] in_sc,
    input  logic [COEF_W-1:0] in_ss,
    output logic              out_valid,
    output logic [COEF_W-1:0] out_cc,
    output logic [COEF_W-1:0] out_cs,
    output logic [COEF_W-1:0] out_sc,
    output logic [COEF_W-1:0] out_ss
);

    localparam int LANES = CPR_LANES;
    localparam int IW    = COEF_W + CPR_GUARD + FRAC;
    localparam int CNT_W = $clog2(ITER + 2) + 1;

    // ---------------- input register bank ----------------
    logic                         bank_vld;
    logic [ITER-1:0]              bank_dir;
    logic [LANES-1:0][COEF_W-1:0] bank_data;
    logic [LANES-1:0][COEF_W-1:0] in_lanes;

    assign in_lanes = {in_ss, in_sc, in_cs, in_cc};

    cpr_bank #(.W(COEF_W), .ITER(ITER), .LANES(LANES)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_in  (in_valid),
        .mode_in (in_mode),
        .dir_in  (in_dirs),
        .data_in (in_lanes),
        .vld_q   (bank_vld),
        .dir_q   (bank_dir),
        .data_q  (bank_data)
    );

    // ---------------- widen to the internal word ----------------
    logic [LANES-1:0][IW-1:0] widened;

    for (genvar l = 0; l < LANES; l++) begin : g_widen
        assign widened[l] = {{CPR_GUARD{bank_data[l][COEF_W-1]}}, bank_data[l], {FRAC{1'b0}}};
    end

    // ---------------- micro-rotation pipeline ----------------
    logic [LANES-1:0][IW-1:0] stg_in  [ITER];
    logic [LANES-1:0][IW-1:0] stg_out [ITER];
    logic                     stg_vld [ITER];
    logic [ITER-1:0]          stg_bit;

    assign stg_in[0]  = widened;
    assign stg_vld[0] = bank_vld;

    for (genvar i = 0; i < ITER; i++) begin : g_stage
        // direction bit i, delayed i cycles to stay aligned with its data
        if (i == 0) begin : g_dir_now
            assign stg_bit[0] = bank_dir[0];
        end else begin : g_dir_dly
            localparam int DW = i;
            logic [DW-1:0] dir_sr;

            // Purpose: delay line aligning direction bit i with stage i.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dir_sr <= '0;
                end else begin
                    dir_sr <= (dir_sr << 1) | DW'(bank_dir[i]);
                end
            end
            assign stg_bit[i] = dir_sr[DW-1];
        end

        cpr_micro_rot #(.IW(IW), .SHIFT(i), .LANES(LANES)) u_rot (
            .lanes_in  (stg_in[i]),
            .rot_ccw   (stg_bit[i]),
            .lanes_out (stg_out[i])
        );

        if (i < ITER - 1) begin : g_pipe
            logic [LANES-1:0][IW-1:0] stage_q;
            logic                     vld_q;

            // Purpose: pipeline latch between micro-rotation i and i+1.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q <= '0;
                    vld_q   <= 1'b0;
                end else begin
                    stage_q <= stg_out[i];
                    vld_q   <= stg_vld[i];
                end
            end
            assign stg_in[i+1]  = stage_q;
            assign stg_vld[i+1] = vld_q;
        end
    end

    // ---------------- gain correction, saturation, output ----------------
    logic [LANES-1:0][COEF_W-1:0] sat_res;
    logic [LANES-1:0][COEF_W-1:0] out_q;
    logic                         out_vld_q;

    for (genvar l = 0; l < LANES; l++) begin : g_gain
        cpr_gain_sat #(.W(COEF_W), .FRAC(FRAC), .IW(IW)) u_gain (
            .val_in  (stg_out[ITER-1][l]),
            .val_out (sat_res[l])
        );
    end

    // Purpose: output register holding the corrected coefficients.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q     <= '0;
            out_vld_q <= 1'b0;
        end else begin
            out_q     <= sat_res;
            out_vld_q <= stg_vld[ITER-1];
        end
    end

    assign out_valid = out_vld_q;
    assign out_cc    = out_q[0];
    assign out_cs    = out_q[1];
    assign out_sc    = out_q[2];
    assign out_ss    = out_q[3];

    // ---------------- checker state and assertions ----------------
    logic [CNT_W-1:0] since_rst;
    logic [CNT_W-1:0] in_flight;

    // Purpose: count edges since reset, saturating past the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst <= CNT_W'(ITER)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    // Purpose: count accepted sets that have not yet left the block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_flight <= '0;
        end else begin
            in_flight <= in_flight + CNT_W'(in_valid) - CNT_W'(out_valid);
        end
    end

    // No result can leave before the pipeline has filled (R1)
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst <= CNT_W'(ITER)) |-> !out_valid);

    // Every result matches an accepted set; never more in flight than stages (R2)
    assert_result_has_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_flight != '0));

    assert_inflight_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_flight <= CNT_W'(ITER + 1));

endmodule

// File: tb/cordic_pair_rotator_tb_top.sv
// Bench: scoreboard for the coefficient plane rotator. The driver task
// computes the expected result from the requirement arithmetic and queues
// it; a monitor pops and compares each result as it leaves the design.
module cordic_pair_rotator_tb_top;

    localparam int W    = 12;
    localparam int ITER = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_mode = 1'b0;
    logic [ITER-1:0] in_dirs = '0;
    logic [W-1:0]    in_cc = '0, in_cs = '0, in_sc = '0, in_ss = '0;
    logic            out_valid;
    logic [W-1:0]    out_cc, out_cs, out_sc, out_ss;

    int  cyc = 0;
    int  n_checks = 0;
    int  n_fails = 0;
    bit  done = 1'b0;

    typedef struct {
        int    cyc;
        int    e [4];
        int    src [4];
        string req;
        bit    mag;
    } item_t;

    item_t sb [$];
    item_t mon_it;

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    cordic_pair_rotator #(.COEF_W(W), .ITER(ITER), .FRAC(2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_mode   (in_mode),
        .in_dirs   (in_dirs),
        .in_cc     (in_cc),
        .in_cs     (in_cs),
        .in_sc     (in_sc),
        .in_ss     (in_ss),
        .out_valid (out_valid),
        .out_cc    (out_cc),
        .out_cs    (out_cs),
        .out_sc    (out_sc),
        .out_ss    (out_ss)
    );

    // ---------------- reference arithmetic from R3..R6 ----------------
    function automatic int sat_ref(int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    function automatic int gain_ref(int v);
        return ((v >>> 1) + (v >>> 3) - (v >>> 6) - (v >>> 9)) >>> 2;
    endfunction

    task automatic rot_ref(input int a, input int b, input logic [ITER-1:0] d,
                           output int oa, output int ob);
        int x;
        int y;
        x = a * 4;
        y = b * 4;
        for (int i = 0; i < ITER; i++) begin
            int xs;
            int ys;
            xs = x >>> i;
            ys = y >>> i;
            if (d[i]) begin
                x = x - ys;
                y = y + xs;
            end else begin
                x = x + ys;
                y = y - xs;
            end
        end
        oa = sat_ref(gain_ref(x));
        ob = sat_ref(gain_ref(y));
    endtask

    function automatic int rnd(int lo, int hi);
        return lo + int'($urandom_range(hi - lo));
    endfunction

    // ---------------- check helper ----------------
    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- driver ----------------
    task automatic send(string req, logic mode, logic [ITER-1:0] d,
                        int a0, int a1, int b0, int b1, bit mag);
        item_t it;
        logic [ITER-1:0] dd;
        @(negedge clk);
        in_valid = 1'b1;
        in_mode  = mode;
        in_dirs  = d;
        in_cc    = W'(a0);
        in_cs    = W'(a1);
        in_sc    = W'(b0);
        in_ss    = W'(b1);
        dd = mode ? ~d : d;                 // R4: backward inverts every bit
        rot_ref(a0, a1, dd, it.e[0], it.e[1]);
        rot_ref(b0, b1, dd, it.e[2], it.e[3]);
        it.src[0] = a0; it.src[1] = a1; it.src[2] = b0; it.src[3] = b1;
        it.cyc = cyc + ITER + 1;            // R2 latency
        it.req = req;
        it.mag = mag;
        sb.push_back(it);
    endtask

    // idle cycles with random junk on the data inputs (R8)
    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_mode  = 1'($urandom_range(1));
            in_dirs  = ITER'($urandom);
            in_cc    = W'($urandom);
            in_cs    = W'($urandom);
            in_sc    = W'($urandom);
            in_ss    = W'($urandom);
        end
    endtask

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                n_checks++;
                n_fails++;
                $display("FAIL R2 unexpected result: actual out_valid 1 expected 0");
            end else begin
                mon_it = sb.pop_front();
                chk("R2", "result cycle", cyc, mon_it.cyc);
                chk(mon_it.req, "out_cc", int'($signed(out_cc)), mon_it.e[0]);
                chk(mon_it.req, "out_cs", int'($signed(out_cs)), mon_it.e[1]);
                chk(mon_it.req, "out_sc", int'($signed(out_sc)), mon_it.e[2]);
                chk(mon_it.req, "out_ss", int'($signed(out_ss)), mon_it.e[3]);
                if (mon_it.mag) begin
                    for (int p = 0; p < 2; p++) begin
                        int a;
                        int b;
                        int pin;
                        int pout;
                        a = (p == 0) ? int'($signed(out_cc)) : int'($signed(out_sc));
                        b = (p == 0) ? int'($signed(out_cs)) : int'($signed(out_ss));
                        pin  = mon_it.src[2*p] * mon_it.src[2*p] + mon_it.src[2*p+1] * mon_it.src[2*p+1];
                        pout = a * a + b * b;
                        n_checks++;
                        if (pout * 100 < pin * 96 || pout * 100 > pin * 104) begin
                            n_fails++;
                            $display("FAIL R7 magnitude pair %0d: actual %0d expected %0d (+-4%%)",
                                     p, pout, pin);
                        end
                    end
                end
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "out_valid in reset", int'(out_valid), 0);
        chk("R1", "out_cc in reset", int'(out_cc), 0);
        chk("R1", "out_cs in reset", int'(out_cs), 0);
        chk("R1", "out_sc in reset", int'(out_sc), 0);
        chk("R1", "out_ss in reset", int'(out_ss), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(ITER);
        chk("R1", "out_valid after release", int'(out_valid), 0);

        // R3: forward mode, zero and fixed patterns
        send("R3", 1'b0, 8'h00, 0, 0, 0, 0, 1'b0);
        send("R3", 1'b0, 8'hA5, 1000, -300, 250, 700, 1'b0);
        send("R3", 1'b0, 8'h3C, -1500, 900, -7, 1, 1'b0);
        send("R3", 1'b0, 8'hFF, 1, -1, 2047, -2048, 1'b0);
        for (int k = 0; k < 4; k++) begin
            send("R3", 1'b0, ITER'($urandom), rnd(-2048, 2047), rnd(-2048, 2047),
                 rnd(-2048, 2047), rnd(-2048, 2047), 1'b0);
        end

        // R4: backward mode
        send("R4", 1'b1, 8'hA5, 1000, -300, 250, 700, 1'b0);
        send("R4", 1'b1, 8'h00, 600, 600, -600, 600, 1'b0);
        for (int k = 0; k < 3; k++) begin
            send("R4", 1'b1, ITER'($urandom), rnd(-2048, 2047), rnd(-2048, 2047),
                 rnd(-2048, 2047), rnd(-2048, 2047), 1'b0);
        end

        // R5: pairs independent, same angle
        send("R5", 1'b0, 8'h5A, 1200, -800, 0, 0, 1'b0);
        send("R5", 1'b0, 8'h5A, 0, 0, 1200, -800, 1'b0);
        send("R5", 1'b1, 8'h96, 1200, -800, 1200, -800, 1'b0);

        // R8: junk while the strobe is low must not disturb anything
        idle(5);
        send("R8", 1'b0, 8'hC3, 333, -444, -555, 666, 1'b0);
        idle(3);
        send("R8", 1'b1, 8'h18, -1024, 512, 77, -1900, 1'b0);
        idle(ITER + 4);

        // R6: saturation at about +-45 degrees (directions 8'hBD)
        send("R6", 1'b0, 8'hBD, 2047, 2047, -2048, -2048, 1'b0);
        send("R6", 1'b1, 8'hBD, 2047, 2047, -2048, -2048, 1'b0);
        send("R6", 1'b0, 8'hBD, -2048, -2048, 2047, 2047, 1'b0);

        // R7: magnitude preserved within tolerance
        for (int k = 0; k < 10; k++) begin
            int s0;
            int s1;
            s0 = $urandom_range(1) ? 1 : -1;
            s1 = $urandom_range(1) ? 1 : -1;
            send("R7", 1'($urandom_range(1)), ITER'($urandom),
                 s0 * rnd(500, 1400), rnd(-1400, 1400),
                 rnd(-1400, 1400), s1 * rnd(500, 1400), 1'b1);
        end

        // R2: long back-to-back burst
        for (int k = 0; k < 16; k++) begin
            send("R2", 1'($urandom_range(1)), ITER'($urandom), rnd(-2048, 2047),
                 rnd(-2048, 2047), rnd(-2048, 2047), rnd(-2048, 2047), 1'b0);
        end

        idle(ITER + 10);
        chk("R2", "pending results", sb.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule